// File: doc/BRIEF.md
# Card-Insert Interrupt Register Bank

This block is the normal-interrupt register group of an SD host controller. It holds three 16-bit registers: an interrupt status register, a status-enable register and a signal-enable register. Software reaches them through a simple single-cycle register bus. Only two status sources are modelled, card insertion and card removal. Each one arrives as a one-cycle hardware strobe. A level interrupt output is formed from status and signal-enable and is registered one cycle behind the register state.

An optional deferred-insert mode can be selected at compile time. In that mode the bank powers up with zero in every register, even though a card is present. It also holds a latent insert event. The event turns into the insert status bit the first time software writes the status-enable register with the insert bit set. A software-triggered controller reset discards the latent event, so it can never appear after that reset. When the mode is off, no latent event exists.

Top module: `sd_nirq_bank`

## Requirements
- R1: After the active-low reset rst_ni is released, all three registers read 0x0000 and irq_o is 0. This holds in both modes.
- R2: With DEFER_INSERT=0, writing the status-enable register with the insert bit set does not set any status bit.
- R3: With DEFER_INSERT=1, the first status-enable write that has the insert bit (bit 6) set makes the insert status bit read 1 directly after that write. Any later enable write never sets it again.
- R4: A status-enable write with the insert bit clear does not release the latent insert event. The event stays available for a later write that sets the insert bit.
- R5: A soft_rst_i pulse zeroes all three registers and discards the latent insert event. Enabling insert afterwards leaves the insert status at 0.
- R6: Status bits are write-1-to-clear. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: An insert or removal strobe sets its status bit (insert at bit 6, removal at bit 7) only while the matching status-enable bit is 1. Otherwise the strobe is ignored.
- R8: Writing 0 to a status-enable bit also clears the matching status bit.
- R9: irq_o equals the OR over all bits of (status AND signal-enable), taken from the register state of the previous cycle.
- R10: Only bits 6 and 7 are implemented in all three registers. All other bits read 0, whatever value was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| soft_rst_i | input | 1 | Synchronous controller reset strobe |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1 |
| addr_i | input | 2 | 0 status, 1 status-enable, 2 signal-enable, 3 reserved |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| insert_evt_i | input | 1 | Card-insert event strobe |
| remove_evt_i | input | 1 | Card-removal event strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The following properties are checked on every cycle:
- A status bit is never set while its enable bit is clear.
- The latent flag never rises after reset.
- A write-1-to-clear takes effect.
- A release occurs on a qualifying enable write.
- A soft reset clears all state.
- The interrupt tracks the registered OR of status AND signal-enable.

Some behaviours need a bench scenario instead, because they depend on history or mode:
- The event is reported only once.
- A write that leaves the insert bit clear keeps the event pending.
- With the mode off nothing is ever released.
- After a soft reset, enabling insert stays silent.

// File: rtl/sd_nirq_pkg.sv
package sd_nirq_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_STEN = 2'd1,
    REG_SGEN = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sd_nirq_decode.sv
module sd_nirq_decode (
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  output logic       wr_stat_o,
  output logic       wr_sten_o,
  output logic       wr_sgen_o
);
  import sd_nirq_pkg::*;
  logic wr;
  assign wr        = req_i & we_i;
  assign wr_stat_o = wr & (reg_sel_e'(addr_i) == REG_STAT);
  assign wr_sten_o = wr & (reg_sel_e'(addr_i) == REG_STEN);
  assign wr_sgen_o = wr & (reg_sel_e'(addr_i) == REG_SGEN);
endmodule

// File: rtl/sd_nirq_pending.sv
module sd_nirq_pending #(
  parameter bit DEFER_INSERT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic wr_sten_i,
  input  logic ins_en_i,
  output logic pend_o,
  output logic rel_o
);
  logic pend_q;

  assign rel_o  = wr_sten_i & ins_en_i & pend_q & ~soft_rst_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= DEFER_INSERT;
    else if (soft_rst_i || rel_o) pend_q <= 1'b0;
  end
endmodule

// File: rtl/sd_nirq_status.sv
module sd_nirq_status #(
  parameter int          W    = 16,
  parameter logic [15:0] MASK = 16'h00C0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         wr_stat_i,
  input  logic         wr_sten_i,
  input  logic         wr_sgen_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] st_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] sig_o
);
  logic unused_bits;
  assign unused_bits = ^(wdata_i & ~MASK[W-1:0]) ^ ^(set_i & ~MASK[W-1:0]);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      logic st_q, en_q, sig_q;
      logic en_nxt, st_nxt;
      assign en_nxt = wr_sten_i ? wdata_i[b] : en_q;
      // event set wins over a same-cycle clear; a disabled bit holds zero
      assign st_nxt = en_nxt & ((st_q & ~(wr_stat_i & wdata_i[b])) | set_i[b]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_q  <= 1'b0;
          en_q  <= 1'b0;
          sig_q <= 1'b0;
        end else if (soft_rst_i) begin
          st_q  <= 1'b0;
          en_q  <= 1'b0;
          sig_q <= 1'b0;
        end else begin
          st_q <= st_nxt;
          en_q <= en_nxt;
          if (wr_sgen_i) sig_q <= wdata_i[b];
        end
      end
      assign st_o[b]  = st_q;
      assign en_o[b]  = en_q;
      assign sig_o[b] = sig_q;
    end else begin : g_none
      assign st_o[b]  = 1'b0;
      assign en_o[b]  = 1'b0;
      assign sig_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/sd_nirq_irq.sv
module sd_nirq_irq #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] st_i,
  input  logic [W-1:0] sig_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(st_i & sig_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/sd_nirq_bank.sv
module sd_nirq_bank #(
  parameter int W            = 16,
  parameter int INS_BIT      = 6,
  parameter int REM_BIT      = 7,
  parameter bit DEFER_INSERT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         insert_evt_i,
  input  logic         remove_evt_i,
  output logic         irq_o
);
  import sd_nirq_pkg::*;

  localparam logic [15:0] MASK = (16'h1 << INS_BIT) | (16'h1 << REM_BIT);

  logic         wr_stat, wr_sten, wr_sgen;
  logic         pend, rel;
  logic [W-1:0] set_vec, st_q, en_q, sig_q;

  sd_nirq_decode u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wr_stat_o(wr_stat), .wr_sten_o(wr_sten), .wr_sgen_o(wr_sgen)
  );

  sd_nirq_pending #(.DEFER_INSERT(DEFER_INSERT)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_sten_i(wr_sten), .ins_en_i(wdata_i[INS_BIT]),
    .pend_o(pend), .rel_o(rel)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[INS_BIT] = insert_evt_i | rel;
    set_vec[REM_BIT] = remove_evt_i;
  end

  sd_nirq_status #(.W(W), .MASK(MASK)) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_stat_i(wr_stat), .wr_sten_i(wr_sten), .wr_sgen_i(wr_sgen),
    .wdata_i(wdata_i), .set_i(set_vec),
    .st_o(st_q), .en_o(en_q), .sig_o(sig_q)
  );

  sd_nirq_irq #(.W(W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_q), .sig_i(sig_q), .irq_o(irq_o)
  );

  always_comb begin
    case (reg_sel_e'(addr_i))
      REG_STAT: rdata_o = st_q;
      REG_STEN: rdata_o = en_q;
      REG_SGEN: rdata_o = sig_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sd_nirq_bank_chk.sv
module sd_nirq_bank_chk #(
  parameter int W       = 16,
  parameter int INS_BIT = 6,
  parameter int REM_BIT = 7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         soft_rst_i,
  input logic         req_i,
  input logic         we_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic         insert_evt_i,
  input logic [W-1:0] st_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] sig_q,
  input logic         pend,
  input logic         irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R8, R7: a status bit never stands without its enable
  a_r8_status_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & ~en_q) == '0);

  // R3: the latent flag only ever falls
  a_r3_pend_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |=> !pend);

  // R3: a qualifying enable write releases the latent event
  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd1 && wdata_i[INS_BIT] && pend && !soft_rst_i)
    |=> (st_q[INS_BIT] && !pend));

  // R6: write-1-to-clear on the insert bit
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd0 && wdata_i[INS_BIT] && !insert_evt_i)
    |=> !st_q[INS_BIT]);

  // R5: controller reset clears everything
  a_r5_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (st_q == '0 && en_q == '0 && sig_q == '0 && !pend));

  // R9: interrupt is the registered OR of status AND signal-enable
  a_r9_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (irq_o == $past(|(st_q & sig_q))));
endmodule

bind sd_nirq_bank sd_nirq_bank_chk #(.W(W), .INS_BIT(INS_BIT), .REM_BIT(REM_BIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
  .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .insert_evt_i(insert_evt_i),
  .st_q(st_q), .en_q(en_q), .sig_q(sig_q), .pend(pend), .irq_o(irq_o)
);

// File: tb/sd_nirq_bank_tb.sv
module sd_nirq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic        ins_evt = 1'b0, rem_evt = 1'b0;
  logic [15:0] rd_on, rd_off;
  logic        irq_on, irq_off;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  sd_nirq_bank #(.DEFER_INSERT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_on), .insert_evt_i(ins_evt),
    .remove_evt_i(rem_evt), .irq_o(irq_on)
  );
  sd_nirq_bank #(.DEFER_INSERT(1'b0)) u_dut_off (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_off), .insert_evt_i(ins_evt),
    .remove_evt_i(rem_evt), .irq_o(irq_off)
  );

  task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v_on, output logic [15:0] v_off);
    addr = a;
    #1;
    v_on = rd_on; v_off = rd_off;
  endtask

  task automatic pulse_evt(input logic ins, input logic rem);
    @(negedge clk);
    ins_evt = ins; rem_evt = rem;
    @(negedge clk);
    ins_evt = 1'b0; rem_evt = 1'b0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] a, b;
    for (int r = 0; r < 3; r++) begin
      rd(r[1:0], a, b);
      check("R1 reg on", a, 16'h0);
      check("R1 reg off", b, 16'h0);
    end
    check("R1 irq", {15'b0, irq_on | irq_off}, 16'h0);
  endtask

  task automatic t_unimpl();
    logic [15:0] a, b;
    wr(2'd2, 16'hFFFF);
    rd(2'd2, a, b);
    check("R10 sgen", a, 16'h00C0);
    rd(2'd3, a, b);
    check("R10 rsvd", a, 16'h0000);
  endtask

  task automatic t_release();
    logic [15:0] a, b;
    wr(2'd1, 16'h0080);
    rd(2'd0, a, b);
    check("R4 no release", a, 16'h0000);
    wr(2'd1, 16'hFFC0);
    rd(2'd0, a, b);
    check("R3 released", a, 16'h0040);
    check("R2 off no release", b, 16'h0000);
    rd(2'd1, a, b);
    check("R10 sten", a, 16'h00C0);
    check("R9 irq lag", {15'b0, irq_on}, 16'h0);
    @(negedge clk);
    check("R9 irq on", {15'b0, irq_on}, 16'h1);
    check("R9 irq off", {15'b0, irq_off}, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] a, b;
    wr(2'd0, 16'h0080);
    rd(2'd0, a, b);
    check("R6 write0 keeps", a, 16'h0040);
    wr(2'd0, 16'h0040);
    rd(2'd0, a, b);
    check("R6 write1 clears", a, 16'h0000);
    @(negedge clk);
    check("R9 irq drops", {15'b0, irq_on}, 16'h0);
    wr(2'd1, 16'h00C0);
    rd(2'd0, a, b);
    check("R3 once only", a, 16'h0000);
  endtask

  task automatic t_events();
    logic [15:0] a, b;
    pulse_evt(1'b1, 1'b0);
    rd(2'd0, a, b);
    check("R7 insert on", a, 16'h0040);
    check("R7 insert off", b, 16'h0040);
    wr(2'd1, 16'h0080);
    rd(2'd0, a, b);
    check("R8 disable clears", a, 16'h0000);
    pulse_evt(1'b1, 1'b0);
    rd(2'd0, a, b);
    check("R7 disabled ignored", a, 16'h0000);
    pulse_evt(1'b0, 1'b1);
    rd(2'd0, a, b);
    check("R7 removal", a, 16'h0080);
    check("R7 removal off", b, 16'h0080);
  endtask

  task automatic t_softrst();
    logic [15:0] a, b;
    hw_reset();
    wr(2'd2, 16'h00C0);
    wr(2'd1, 16'h0080);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    rd(2'd2, a, b);
    check("R5 sgen cleared", a, 16'h0000);
    rd(2'd1, a, b);
    check("R5 sten cleared", a, 16'h0000);
    wr(2'd1, 16'h0040);
    rd(2'd0, a, b);
    check("R5 no deferred", a, 16'h0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unimpl();
        t_release();
        t_w1c();
        t_events();
        t_softrst();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule